// File: doc/BRIEF.md
# Bus Master Security Wrapper

This wrapper sits between one legacy bus master and the system interconnect. The master has no notion of security state of its own. The wrapper supplies one: a configured security bit and a configured privilege bit. For every address phase it presents the address to an external lite attribution lookup. The lookup answers combinationally with one bit, Secure or Non-secure. The wrapper then either forwards the transfer with the matching security attribute, or blocks it.

Blocking happens only when a Secure address is seen from a master configured as Non-secure. A blocked transfer never reaches the interconnect. Its data phase completes in a single cycle with an OKAY response: a read returns zeros and write data is withheld.

The first fault after a clear latches the master identifier and the offending address and raises a sticky flag. Later faults leave that record unchanged until software clears the flag with a write-one-to-clear strobe. An interrupt output follows the flag when its enable is high.

Top module: `bm_sec_wrapper`

## Requirements
- R1: After reset the flag and the interrupt are low and the master is configured Secure and privileged. A Secure-looked-up transfer to peripheral space is forwarded with `s_nonsec`=0 and `s_priv`=1.
- R2: When `lk_secure`=0 the transfer is forwarded with `s_nonsec`=1, whatever the master's configuration. The read data of a forwarded read is `s_rdata`.
- R3: When `lk_secure`=1 and the master is configured Secure, the transfer is forwarded with `s_nonsec`=0.
- R4: When `lk_secure`=1 and the master is configured Non-secure, the address phase is not forwarded: `s_trans`=0 and `s_write`=0.
- R5: In the data phase of a blocked read, `m_ready`=1, `m_resp`=0 (OKAY) and `m_rdata` is all zeros.
- R6: In the data phase of a blocked write, `s_wdata` is all zeros. On a forwarded write, `s_wdata` carries `m_wdata`.
- R7: An accepted blocked transfer sets `fault_flag` from the next cycle. If the flag was clear, `fault_mid` takes MASTER_ID and `fault_addr` takes the transfer address.
- R8: While `fault_flag` is set, further faults change neither `fault_mid` nor `fault_addr`.
- R9: `fault_flag` clears on a cycle with `clr_wr`=1 and `clr_bit`=1. A strobe with `clr_bit`=0 has no effect. A fault accepted in the same cycle as a clear keeps the flag set and records the new fault.
- R10: `irq` is high exactly when `fault_flag` and `irq_en` are both high.
- R11: `s_priv` equals the configured privilege bit for addresses in [PERIPH_BASE, PERIPH_LIMIT). For all other addresses it is 1.
- R12: A cycle with `cfg_wr`=1 loads `cfg_sec_wd` as the security bit (1 = Secure) and `cfg_priv_wd` as the privilege bit (1 = privileged). The new values apply from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration load strobe |
| cfg_sec_wd | input | 1 | New security bit, 1 = Secure |
| cfg_priv_wd | input | 1 | New privilege bit, 1 = privileged |
| irq_en | input | 1 | Interrupt enable |
| clr_wr | input | 1 | Flag clear strobe |
| clr_bit | input | 1 | Clear data bit, 1 clears |
| m_trans | input | 1 | Master address phase valid |
| m_write | input | 1 | Master write, 1 = write |
| m_addr | input | AW | Master address |
| m_wdata | input | DW | Master write data |
| m_rdata | output | DW | Read data to master |
| m_ready | output | 1 | Data phase complete to master |
| m_resp | output | 1 | Response to master, 0 = OKAY |
| lk_addr | output | AW | Address sent to the attribution lookup |
| lk_secure | input | 1 | Lookup result, 1 = Secure |
| s_trans | output | 1 | Downstream address phase valid |
| s_write | output | 1 | Downstream write |
| s_addr | output | AW | Downstream address |
| s_wdata | output | DW | Downstream write data |
| s_nonsec | output | 1 | Downstream security attribute, 1 = Non-secure |
| s_priv | output | 1 | Downstream privilege attribute |
| s_rdata | input | DW | Downstream read data |
| s_ready | input | 1 | Downstream ready |
| s_resp | input | 1 | Downstream response |
| fault_flag | output | 1 | Sticky security fault flag |
| fault_mid | output | MIDW | Recorded master identifier |
| fault_addr | output | AW | Recorded fault address |
| irq | output | 1 | Interrupt request |

## Verification
The bench sends reads and writes across every combination of lookup result and master configuration, and it compares each one against a scoreboard entry. A design that forwarded a blocked transfer, or mislabelled a Non-secure lookup, shows up on `s_trans` or `s_nonsec`. A design that leaked downstream data on a blocked read shows up on `m_rdata`. Privilege is probed at both ends of the peripheral window, including the first address past it, where an off-by-one decode flips `s_priv`. The fault record is tested with a second fault while the flag is set, a clear strobe with a zero data bit, and a fault coincident with a clear. A recorder that overwrote, ignored the data bit, or let the clear win would report the wrong address or flag.

// File: rtl/bm_sec_pkg.sv
package bm_sec_pkg;

    typedef enum logic {
        ATTR_SECURE = 1'b0,
        ATTR_NONSEC = 1'b1
    } bus_attr_e;

    typedef struct packed {
        logic sec;
        logic priv;
    } master_cfg_t;

    localparam master_cfg_t CFG_RESET = '{sec: 1'b1, priv: 1'b1};

    typedef struct packed {
        logic      fwd;
        logic      fault;
        bus_attr_e attr;
    } gate_dec_t;

    function automatic gate_dec_t gate_decide(input logic valid,
                                              input logic lk_sec,
                                              input logic master_sec);
        gate_dec_t d;
        d.attr  = lk_sec ? ATTR_SECURE : ATTR_NONSEC;
        d.fault = valid & lk_sec & ~master_sec;
        d.fwd   = valid & ~d.fault;
        return d;
    endfunction

endpackage

// File: rtl/bm_sec_cfg.sv
module bm_sec_cfg
    import bm_sec_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        wr,
    input  logic        sec_wd,
    input  logic        priv_wd,
    output master_cfg_t cfg
);
    always_ff @(posedge clk) begin
        if (rst)     cfg <= CFG_RESET;
        else if (wr) cfg <= '{sec: sec_wd, priv: priv_wd};
    end

    AST_CFG_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr |=> (cfg.sec == $past(sec_wd)) && (cfg.priv == $past(priv_wd))); // R12
endmodule

// File: rtl/bm_sec_gate.sv
module bm_sec_gate
    import bm_sec_pkg::*;
#(
    parameter int          AW           = 32,
    parameter logic [AW-1:0] PERIPH_BASE  = 32'h4000_0000,
    parameter logic [AW-1:0] PERIPH_LIMIT = 32'h6000_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        trans,
    input  logic        write,
    input  logic [AW-1:0] addr,
    input  logic        lk_secure,
    input  master_cfg_t cfg,
    output gate_dec_t   dec,
    output logic        s_trans,
    output logic        s_write,
    output logic        s_nonsec,
    output logic        s_priv
);
    logic in_periph;

    always_comb begin
        dec       = gate_decide(trans, lk_secure, cfg.sec);
        in_periph = (addr >= PERIPH_BASE) && (addr < PERIPH_LIMIT);
        s_trans   = dec.fwd;
        s_write   = dec.fwd & write;
        s_nonsec  = (dec.attr == ATTR_NONSEC);
        s_priv    = in_periph ? cfg.priv : 1'b1;
    end

    AST_NS_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (trans && !lk_secure) |-> (s_trans && s_nonsec)); // R2
    AST_SEC_FORWARD: assert property (@(posedge clk) disable iff (rst)
        (trans && lk_secure && cfg.sec) |-> (s_trans && !s_nonsec)); // R3
    AST_BLOCK_SEC: assert property (@(posedge clk) disable iff (rst)
        (trans && lk_secure && !cfg.sec) |-> (!s_trans && !s_write)); // R4
endmodule

// File: rtl/bm_sec_fault.sv
module bm_sec_fault #(
    parameter int            AW        = 32,
    parameter int            MIDW      = 4,
    parameter logic [MIDW-1:0] MASTER_ID = 4'hA
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hit,
    input  logic [AW-1:0]   hit_addr,
    input  logic            clr_wr,
    input  logic            clr_bit,
    input  logic            irq_en,
    output logic            flag,
    output logic [MIDW-1:0] mid,
    output logic [AW-1:0]   addr,
    output logic            irq
);
    logic clr;
    assign clr = clr_wr & clr_bit;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
            mid  <= '0;
            addr <= '0;
        end else if (hit && (!flag || clr)) begin
            flag <= 1'b1;
            mid  <= MASTER_ID;
            addr <= hit_addr;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

    assign irq = flag & irq_en;

    AST_FAULT_SETS: assert property (@(posedge clk) disable iff (rst)
        hit |=> flag); // R7
    AST_RECORD_FROZEN: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> (flag && $stable(addr) && $stable(mid))); // R8
    AST_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (clr && !hit) |=> !flag); // R9
    AST_IRQ_MASK: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> !irq); // R10
endmodule

// File: rtl/bm_sec_dphase.sv
module bm_sec_dphase #(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          blk_accept,
    input  logic          s_ready,
    input  logic          s_resp,
    input  logic [DW-1:0] s_rdata,
    input  logic [DW-1:0] m_wdata,
    output logic          m_ready,
    output logic          m_resp,
    output logic [DW-1:0] m_rdata,
    output logic [DW-1:0] s_wdata
);
    logic blk_q;

    always_ff @(posedge clk) begin
        if (rst)          blk_q <= 1'b0;
        else if (m_ready) blk_q <= blk_accept;
    end

    always_comb begin
        m_ready = blk_q | s_ready;
        m_resp  = blk_q ? 1'b0 : s_resp;
        m_rdata = blk_q ? '0 : s_rdata;
        s_wdata = blk_q ? '0 : m_wdata;
    end

    AST_BLOCK_RAZ: assert property (@(posedge clk) disable iff (rst)
        $past(blk_accept) |-> (m_ready && !m_resp && (m_rdata == '0))); // R5
    AST_BLOCK_WI: assert property (@(posedge clk) disable iff (rst)
        $past(blk_accept) |-> (s_wdata == '0)); // R6
endmodule

// File: rtl/bm_sec_wrapper.sv
module bm_sec_wrapper
    import bm_sec_pkg::*;
#(
    parameter int              AW           = 32,
    parameter int              DW           = 32,
    parameter int              MIDW         = 4,
    parameter logic [MIDW-1:0] MASTER_ID    = 4'hA,
    parameter logic [AW-1:0]   PERIPH_BASE  = 32'h4000_0000,
    parameter logic [AW-1:0]   PERIPH_LIMIT = 32'h6000_0000
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            cfg_wr,
    input  logic            cfg_sec_wd,
    input  logic            cfg_priv_wd,
    input  logic            irq_en,
    input  logic            clr_wr,
    input  logic            clr_bit,
    input  logic            m_trans,
    input  logic            m_write,
    input  logic [AW-1:0]   m_addr,
    input  logic [DW-1:0]   m_wdata,
    output logic [DW-1:0]   m_rdata,
    output logic            m_ready,
    output logic            m_resp,
    output logic [AW-1:0]   lk_addr,
    input  logic            lk_secure,
    output logic            s_trans,
    output logic            s_write,
    output logic [AW-1:0]   s_addr,
    output logic [DW-1:0]   s_wdata,
    output logic            s_nonsec,
    output logic            s_priv,
    input  logic [DW-1:0]   s_rdata,
    input  logic            s_ready,
    input  logic            s_resp,
    output logic            fault_flag,
    output logic [MIDW-1:0] fault_mid,
    output logic [AW-1:0]   fault_addr,
    output logic            irq
);
    master_cfg_t cfg;
    gate_dec_t   dec;
    logic        blk_accept;

    assign lk_addr    = m_addr;
    assign s_addr     = m_addr;
    assign blk_accept = dec.fault & m_ready;

    bm_sec_cfg u_cfg (
        .clk(clk), .rst(rst), .wr(cfg_wr),
        .sec_wd(cfg_sec_wd), .priv_wd(cfg_priv_wd), .cfg(cfg)
    );

    bm_sec_gate #(.AW(AW), .PERIPH_BASE(PERIPH_BASE), .PERIPH_LIMIT(PERIPH_LIMIT)) u_gate (
        .clk(clk), .rst(rst), .trans(m_trans), .write(m_write), .addr(m_addr),
        .lk_secure(lk_secure), .cfg(cfg), .dec(dec),
        .s_trans(s_trans), .s_write(s_write), .s_nonsec(s_nonsec), .s_priv(s_priv)
    );

    bm_sec_fault #(.AW(AW), .MIDW(MIDW), .MASTER_ID(MASTER_ID)) u_fault (
        .clk(clk), .rst(rst), .hit(blk_accept), .hit_addr(m_addr),
        .clr_wr(clr_wr), .clr_bit(clr_bit), .irq_en(irq_en),
        .flag(fault_flag), .mid(fault_mid), .addr(fault_addr), .irq(irq)
    );

    bm_sec_dphase #(.DW(DW)) u_dphase (
        .clk(clk), .rst(rst), .blk_accept(blk_accept),
        .s_ready(s_ready), .s_resp(s_resp), .s_rdata(s_rdata), .m_wdata(m_wdata),
        .m_ready(m_ready), .m_resp(m_resp), .m_rdata(m_rdata), .s_wdata(s_wdata)
    );

    AST_RESET_STATE: assert property (@(posedge clk)
        $past(rst) |-> (!fault_flag && !irq)); // R1
endmodule

// File: tb/test_bm_sec_wrapper.sv
module test_bm_sec_wrapper;
    localparam logic [31:0] RD = 32'h1234_5678;
    localparam logic [31:0] WD = 32'hA5A5_0F0F;
    localparam logic [3:0]  MID = 4'hA;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic cfg_wr = 0, cfg_sec_wd = 0, cfg_priv_wd = 0, irq_en = 0, clr_wr = 0, clr_bit = 0;
    logic m_trans = 0, m_write = 0, lk_secure = 0;
    logic [31:0] m_addr = '0, m_wdata = '0;
    logic [31:0] m_rdata, lk_addr, s_addr, s_wdata, fault_addr;
    logic m_ready, m_resp, s_trans, s_write, s_nonsec, s_priv, fault_flag, irq;
    logic [3:0] fault_mid;

    bm_sec_wrapper i_bm_sec_wrapper (
        .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_sec_wd(cfg_sec_wd), .cfg_priv_wd(cfg_priv_wd),
        .irq_en(irq_en), .clr_wr(clr_wr), .clr_bit(clr_bit),
        .m_trans(m_trans), .m_write(m_write), .m_addr(m_addr), .m_wdata(m_wdata),
        .m_rdata(m_rdata), .m_ready(m_ready), .m_resp(m_resp),
        .lk_addr(lk_addr), .lk_secure(lk_secure),
        .s_trans(s_trans), .s_write(s_write), .s_addr(s_addr), .s_wdata(s_wdata),
        .s_nonsec(s_nonsec), .s_priv(s_priv), .s_rdata(RD), .s_ready(1'b1), .s_resp(1'b0),
        .fault_flag(fault_flag), .fault_mid(fault_mid), .fault_addr(fault_addr), .irq(irq)
    );

    typedef struct {
        logic [31:0] addr;
        logic        wr;
        logic        fwd;
        logic        ns;
        logic        priv;
        logic [31:0] rdata;
        logic [31:0] wdata;
        string       req;
    } exp_t;

    exp_t sb[$];
    int n_chk = 0;
    int n_err = 0;
    logic mdl_sec = 1'b1;
    logic mdl_priv = 1'b1;

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_err++;
            $display("FAIL %s got=%0h exp=%0h", req, got, exp);
        end
    endtask

    task automatic xfer(input logic [31:0] a, input logic wr, input logic lk,
                        input logic clr, input string req);
        exp_t e;
        logic periph;
        @(posedge clk); #1;
        periph   = (a >= 32'h4000_0000) && (a < 32'h6000_0000);
        e.addr   = a;
        e.wr     = wr;
        e.fwd    = !(lk && !mdl_sec);
        e.ns     = !lk;
        e.priv   = periph ? mdl_priv : 1'b1;
        e.rdata  = e.fwd ? RD : 32'h0;
        e.wdata  = e.fwd ? WD : 32'h0;
        e.req    = req;
        sb.push_back(e);
        m_trans = 1; m_write = wr; m_addr = a; m_wdata = WD; lk_secure = lk;
        clr_wr = clr; clr_bit = clr;
        @(posedge clk); #1;
        m_trans = 0; m_write = 0; clr_wr = 0; clr_bit = 0;
    endtask

    task automatic cfg_load(input logic sec, input logic priv);
        @(posedge clk); #1;
        cfg_wr = 1; cfg_sec_wd = sec; cfg_priv_wd = priv;
        mdl_sec = sec; mdl_priv = priv;
        @(posedge clk); #1;
        cfg_wr = 0;
    endtask

    task automatic clear(input logic b);
        @(posedge clk); #1;
        clr_wr = 1; clr_bit = b;
        @(posedge clk); #1;
        clr_wr = 0; clr_bit = 0;
    endtask

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    // monitor / scoreboard
    initial begin
        forever begin
            exp_t e;
            @(negedge clk);
            if (m_trans) begin
                if (sb.size() == 0) begin
                    chk("scoreboard underflow", 1, 0);
                end else begin
                    e = sb.pop_front();
                    chk({e.req, " s_trans"}, s_trans, e.fwd);
                    chk({e.req, " s_write"}, s_write, e.fwd & e.wr);
                    if (e.fwd) begin
                        chk({e.req, " s_nonsec"}, s_nonsec, e.ns);
                        chk({e.req, " s_priv"}, s_priv, e.priv);
                        chk({e.req, " s_addr"}, s_addr, e.addr);
                    end
                    @(negedge clk);
                    chk({e.req, " m_ready"}, m_ready, 1);
                    chk({e.req, " m_resp"}, m_resp, 0);
                    if (e.wr) chk({e.req, " s_wdata"}, s_wdata, e.wdata);
                    else      chk({e.req, " m_rdata"}, m_rdata, e.rdata);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_err++;
        $display("FAIL watchdog expired got=running exp=done");
        report();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        chk("R1 reset flag", fault_flag, 0);
        chk("R1 reset irq", irq, 0);
        chk("R1 reset ready", m_ready, 1);
        chk("R1 reset idle", s_trans, 0);

        xfer(32'h4000_0100, 0, 1, 0, "R1 default secure priv periph");
        xfer(32'h2000_0040, 0, 0, 0, "R2 ns lookup read");
        xfer(32'h2000_0080, 1, 1, 0, "R3 secure write passthrough R6");

        cfg_load(0, 0); // R12
        xfer(32'h5000_0000, 0, 0, 0, "R11 periph unpriv R12");
        xfer(32'h2000_1000, 0, 0, 0, "R11 ram ignores priv");
        xfer(32'h5FFF_FFFC, 0, 0, 0, "R11 periph top");
        xfer(32'h6000_0000, 0, 0, 0, "R11 past periph");
        xfer(32'h3FFF_FFFC, 0, 0, 0, "R11 below periph");

        xfer(32'h0800_2000, 0, 1, 0, "R4 R5 blocked read");
        @(negedge clk);
        chk("R7 flag set", fault_flag, 1);
        chk("R7 mid", fault_mid, MID);
        chk("R7 addr", fault_addr, 32'h0800_2000);
        chk("R10 irq masked", irq, 0);
        irq_en = 1;
        #1 chk("R10 irq enabled", irq, 1);

        xfer(32'h0800_3000, 1, 1, 0, "R4 R6 blocked write");
        @(negedge clk);
        chk("R8 addr frozen", fault_addr, 32'h0800_2000);
        chk("R8 flag held", fault_flag, 1);

        clear(0);
        @(negedge clk);
        chk("R9 zero bit ignored", fault_flag, 1);
        clear(1);
        @(negedge clk);
        chk("R9 cleared", fault_flag, 0);
        chk("R10 irq follows flag", irq, 0);

        xfer(32'h0C00_0000, 0, 1, 0, "R4 fault A");
        xfer(32'h0C00_0100, 0, 1, 1, "R9 fault with clear");
        @(negedge clk);
        chk("R9 same cycle flag", fault_flag, 1);
        chk("R9 same cycle addr", fault_addr, 32'h0C00_0100);

        cfg_load(1, 1);
        xfer(32'h0800_2000, 0, 1, 0, "R3 secure master secure addr");
        xfer(32'h4000_2000, 1, 0, 0, "R2 R11 ns write periph priv");
        @(negedge clk);
        chk("R8 no new record", fault_addr, 32'h0C00_0100);

        repeat (2) @(posedge clk);
        if (sb.size() != 0) chk("scoreboard drained", sb.size(), 0);
        report();
    end
endmodule